// File: doc/BRIEF.md
# PWM Pulse Steering Unit

This block takes the single waveform from an existing PWM generator and distributes it to four output pins. Each pin has its own steering enable in a small control register. A pin whose enable is set carries the PWM waveform. A pin whose enable is clear carries its ordinary port data bit. Any combination of the four pins may carry the waveform at the same time. Steering is honoured only while the surrounding PWM logic is in single-output mode. In any other mode every pin falls back to port data.

A sync bit in the control register chooses when new enables take effect. With the bit clear, an update applies on the next clock. With it set, the written enables wait in a shadow copy until the next PWM period-start strobe. A 2-bit polarity field, taken from the low bits of the mode input, sets the active level of each steered pin. A shutdown request forces every steered pin to its inactive level at once. The pins stay forced until a period-start strobe arrives with the request removed. Pins that carry port data are never touched by shutdown.

The register interface and the pin inputs are plain control signals with no handshake. A write is taken on every clock in which `wr_en` is high, and the block never pushes back on it.

Top module: `pwm_steer_unit`

## Requirements
- R1: After reset the control readback is 0x01 (sync clear, only the enable for pin A set). In single-output mode, pin A then carries the PWM waveform and pins B, C and D carry port data.
- R2: In single-output mode, a pin whose active enable is 1 carries `pwm_in`, passed through that pin's polarity, in the same cycle.
- R3: In single-output mode, a pin whose active enable is 0 carries its `port_data` bit, whatever `pwm_in` and `shutdown_req` do.
- R4: Single-output mode means `mode_sel[3:2]` = 11 and `out_cfg` = 00. In any other setting, `pin_out` equals `port_data`.
- R5: Polarity is `mode_sel[1:0]`, and pins are numbered A=0, B=1, C=2, D=3. Pins A and C are inverted when bit 1 is set; pins B and D are inverted when bit 0 is set. So 00 gives all pins active-high, 01 inverts B and D, 10 inverts A and C, and 11 inverts all four.
- R6: The control byte is laid out as {3'b000, sync, enD, enC, enB, enA}. A write with bit 4 = 0 makes its bits 3:0 the active enables from the next cycle on.
- R7: A write with bit 4 = 1 leaves the active enables unchanged. While the stored sync bit is 1, each period-start strobe copies the stored enables to the active set, and the change is seen from the cycle after the strobe.
- R8: `rd_data` returns the last written bits 4:0 from the cycle after the write. Bits 7:5 always read 0.
- R9: While `shutdown_req` is high, every steered pin sits at its inactive level: 0 if active-high, 1 if active-low. This starts in the same cycle the request rises.
- R10: Once the request falls, steered pins stay at the inactive level until a clock edge at which `period_start` is high and `shutdown_req` is low. The waveform returns in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM waveform from the generator |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| port_data | input | 4 | Ordinary port data per pin, bit 0 = pin A |
| shutdown_req | input | 1 | Auto-shutdown request |
| mode_sel | input | 4 | Mode field; [3:2] = 11 selects PWM, [1:0] is the polarity |
| out_cfg | input | 2 | Output configuration; 00 selects single-output mode |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register readback |
| pin_out | output | 4 | Pin levels, bit 0 = pin A |

## Verification
The assertions assume that `mode_sel`, `out_cfg`, `shutdown_req` and `port_data` are stable around each rising edge. They also assume that `period_start` is a level sampled on that edge, not a pulse narrower than a clock. The stimulus meets these assumptions by changing every input only on the falling edge and by holding each strobe for exactly one full cycle. The stimulus places writes in the same cycle as strobes and keeps shutdown high across strobes. It also lowers shutdown well before a strobe arrives, so that each ordering the properties speak about is exercised.

// File: rtl/pwm_steer_pkg.sv
`timescale 1ns/1ps
package pwm_steer_pkg;
  localparam logic [1:0] PWM_MODE_HI  = 2'b11;
  localparam logic [1:0] OUTCFG_SINGLE = 2'b00;

  // even pins (A, C) follow polarity bit 1, odd pins (B, D) follow bit 0
  function automatic logic pin_inverted(input logic [1:0] pol, input int unsigned idx);
    return (idx % 2 == 0) ? pol[1] : pol[0];
  endfunction
endpackage

// File: rtl/steer_regs.sv
`timescale 1ns/1ps
module steer_regs #(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned CTRL_W = 8,
  parameter logic [NPINS-1:0] RST_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              period_start,
  output logic [NPINS-1:0]  act_en,
  output logic [CTRL_W-1:0] rd_data
);
  localparam int unsigned SYNC_BIT = NPINS;
  localparam int unsigned FIELD_W  = NPINS + 1;

  logic [FIELD_W-1:0] wr_q;   // last written value, also the shadow enables

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= {1'b0, RST_EN};
    end else if (wr_en) begin
      wr_q <= wr_data[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en <= RST_EN;
    end else if (wr_en && !wr_data[SYNC_BIT]) begin
      act_en <= wr_data[NPINS-1:0];
    end else if (period_start && wr_q[SYNC_BIT]) begin
      act_en <= wr_q[NPINS-1:0];
    end
  end

  assign rd_data = CTRL_W'(wr_q);
endmodule

// File: rtl/steer_shutdown.sv
`timescale 1ns/1ps
module steer_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_req,
  input  logic period_start,
  output logic sd_q,
  output logic sd_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_q <= 1'b0;
    end else if (shutdown_req) begin
      sd_q <= 1'b1;
    end else if (period_start) begin
      sd_q <= 1'b0;
    end
  end

  // request acts at once; latched state holds until a clean period start
  assign sd_hold = shutdown_req | sd_q;
endmodule

// File: rtl/steer_pin.sv
`timescale 1ns/1ps
module steer_pin (
  input  logic steer_on,
  input  logic en,
  input  logic inv,
  input  logic sd_hold,
  input  logic pwm_in,
  input  logic port_bit,
  output logic pin
);
  always_comb begin
    if (steer_on && en) begin
      pin = sd_hold ? inv : (pwm_in ^ inv);
    end else begin
      pin = port_bit;
    end
  end
endmodule

// File: rtl/pwm_steer_unit.sv
`timescale 1ns/1ps
module pwm_steer_unit #(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned CTRL_W = 8,
  parameter logic [NPINS-1:0] RST_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              period_start,
  input  logic [NPINS-1:0]  port_data,
  input  logic              shutdown_req,
  input  logic [3:0]        mode_sel,
  input  logic [1:0]        out_cfg,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic [NPINS-1:0]  pin_out
);
  import pwm_steer_pkg::*;

  logic [NPINS-1:0] act_en;
  logic             sd_q;
  logic             sd_hold;
  logic             steer_on;

  assign steer_on = (mode_sel[3:2] == PWM_MODE_HI) && (out_cfg == OUTCFG_SINGLE);

  steer_regs #(.NPINS(NPINS), .CTRL_W(CTRL_W), .RST_EN(RST_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period_start(period_start), .act_en(act_en), .rd_data(rd_data)
  );

  steer_shutdown u_sd (
    .clk(clk), .rst_n(rst_n), .shutdown_req(shutdown_req),
    .period_start(period_start), .sd_q(sd_q), .sd_hold(sd_hold)
  );

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    steer_pin u_pin (
      .steer_on(steer_on), .en(act_en[gi]),
      .inv(pin_inverted(mode_sel[1:0], gi)), .sd_hold(sd_hold),
      .pwm_in(pwm_in), .port_bit(port_data[gi]), .pin(pin_out[gi])
    );
  end
endmodule

// File: rtl/steer_chk.sv
`timescale 1ns/1ps
module steer_chk #(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              period_start,
  input logic [NPINS-1:0]  port_data,
  input logic              shutdown_req,
  input logic [3:0]        mode_sel,
  input logic [1:0]        out_cfg,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] rd_data,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  act_en,
  input logic              sd_q
);
  import pwm_steer_pkg::*;

  logic single_mode;
  assign single_mode = (mode_sel[3:2] == 2'b11) && (out_cfg == 2'b00);

  // R8
  rd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> (NPINS + 1)) == '0);

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[NPINS:0] == $past(wr_data[NPINS:0]));

  // R6
  immediate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[NPINS]) |=> act_en == $past(wr_data[NPINS-1:0]));

  // R7
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_data[NPINS]) && !period_start) |=> $stable(act_en));

  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> pin_out == port_data);

  // R10
  sd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_q && !period_start) |=> sd_q);

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_sd
    // R9
    sd_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_req && single_mode && act_en[gi]) |->
        pin_out[gi] == pin_inverted(mode_sel[1:0], gi));
  end
endmodule

bind pwm_steer_unit steer_chk #(.NPINS(NPINS), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_start(period_start), .port_data(port_data),
  .shutdown_req(shutdown_req), .mode_sel(mode_sel), .out_cfg(out_cfg),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out),
  .act_en(act_en), .sd_q(sd_q)
);

// File: tb/test_pwm_steer_unit.sv
`timescale 1ns/1ps
module test_pwm_steer_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pwm_in = 0, period_start = 0, shutdown_req = 0, wr_en = 0;
  logic [3:0] port_data = 0, mode_sel = 4'b1100;
  logic [1:0] out_cfg = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [3:0] pin_out;

  // staging values applied at the next falling edge
  logic       s_ps = 0, s_sd = 0, s_wr = 0;
  logic [7:0] s_wd = 0;
  logic [3:0] s_mode = 4'b1100;
  logic [1:0] s_cfg = 0;

  // reference model state
  logic [4:0] m_wr = 5'b00001;
  logic [3:0] m_act = 4'b0001;
  logic       m_sd = 0;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_steer_unit i_pwm_steer_unit (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .port_data(port_data), .shutdown_req(shutdown_req), .mode_sel(mode_sel),
    .out_cfg(out_cfg), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_out(pin_out)
  );

  function automatic logic [3:0] exp_pins();
    logic [3:0] e;
    logic st;
    st = (mode_sel[3:2] == 2'b11) && (out_cfg == 2'b00);
    for (int i = 0; i < 4; i++) begin
      logic inv;
      inv = (i % 2 == 0) ? mode_sel[1] : mode_sel[0];
      if (st && m_act[i]) e[i] = (shutdown_req || m_sd) ? inv : (pwm_in ^ inv);
      else e[i] = port_data[i];
    end
    return e;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    pwm_in = 1'($urandom);
    port_data = 4'($urandom);
    period_start = s_ps; shutdown_req = s_sd; wr_en = s_wr; wr_data = s_wd;
    mode_sel = s_mode; out_cfg = s_cfg;
    s_ps = 0; s_wr = 0;
    #1;
    chk({tag, " pins"}, {4'h0, pin_out}, {4'h0, exp_pins()});
    chk("R8 readback", rd_data, {3'b000, m_wr});
    @(posedge clk);
    if (!rst_n) begin
      m_wr = 5'b00001; m_act = 4'b0001; m_sd = 0;
    end else begin
      if (wr_en && !wr_data[4]) m_act = wr_data[3:0];
      else if (period_start && m_wr[4]) m_act = m_wr[3:0];
      if (wr_en) m_wr = wr_data[4:0];
      if (shutdown_req) m_sd = 1;
      else if (period_start) m_sd = 0;
    end
  endtask

  task automatic write(logic [7:0] v);
    s_wr = 1; s_wd = v;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick("R1");
    @(negedge clk); rst_n = 1;
    // R1: reset default, only pin A steered
    for (int k = 0; k < 4; k++) tick("R1");
    chk("R1 rd reset", rd_data, 8'h01);

    // R2 R3 R5: enable patterns under each polarity
    for (int p = 0; p < 4; p++) begin
      s_mode = {2'b11, 2'(p)};
      write(8'h0F); tick("R5");
      for (int k = 0; k < 4; k++) tick("R2");
      write(8'h06); tick("R5");
      for (int k = 0; k < 4; k++) tick("R3");
    end

    // R4: not single-output mode
    s_cfg = 2'b01; for (int k = 0; k < 4; k++) tick("R4");
    s_cfg = 0; s_mode = 4'b1000; for (int k = 0; k < 4; k++) tick("R4");
    s_mode = 4'b1100;

    // R6: immediate update
    write(8'h0A); tick("R6"); tick("R6");
    write(8'hE5); tick("R6"); tick("R8");  // upper bits ignored on readback

    // R7: sync update held until strobe
    write(8'h13); tick("R7");
    for (int k = 0; k < 5; k++) tick("R7");
    s_ps = 1; tick("R7");
    tick("R7"); tick("R7");
    write(8'h1C); s_ps = 1; tick("R7");  // write coincides with strobe
    tick("R7"); s_ps = 1; tick("R7"); tick("R7");

    // R9 R10: shutdown
    write(8'h0F); tick("R9");
    s_sd = 1; for (int k = 0; k < 3; k++) tick("R9");
    s_ps = 1; tick("R9");          // strobe with request high: no release
    s_sd = 0; for (int k = 0; k < 4; k++) tick("R10");
    s_ps = 1; tick("R10");
    for (int k = 0; k < 3; k++) tick("R10");
    write(8'h05); tick("R3");
    s_sd = 1; for (int k = 0; k < 3; k++) tick("R3");  // B and D keep port data
    s_sd = 0; s_ps = 1; tick("R10"); tick("R10");

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      s_ps = ($urandom % 5 == 0);
      s_sd = ($urandom % 9 == 0);
      if ($urandom % 6 == 0) write(8'($urandom));
      if ($urandom % 20 == 0) s_mode = 4'($urandom);
      if ($urandom % 20 == 0) s_cfg = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 25 == 0) s_mode = {2'b11, 2'($urandom)};
      tick("R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule